// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Presenter

This block is the processor-facing end of a multi-source interrupt controller. Source logic upstream hands it delivery requests, each naming an interrupt number together with a 4-bit priority and an 8-bit vector. The block keeps two bit-sets indexed by interrupt number. The pending set holds interrupts waiting to be taken. The in-service set holds interrupts the processor has taken and not yet retired. It drives one interrupt line toward the processor.

A request is accepted only if its priority clears the task-priority threshold and its bit is not already pending. The line is raised only if the new interrupt is not masked by a higher pending entry or by a higher in-service entry. The processor uses an acknowledge strobe to take the best pending interrupt and read back its vector. It uses an end-of-interrupt strobe to retire the best in-service interrupt. Both of these re-evaluate the line. When several events land in one clock, they are applied in a fixed order: acknowledge first, then end-of-interrupt, then delivery.

The block stores the priority and vector of each interrupt when that interrupt is accepted. Later searches and acknowledges use this stored copy.

Top module: `irq_presenter`

## Requirements
- R1: A request with `req_prio` less than or equal to the task priority gives `req_accept` = 0 in that cycle and leaves no pending entry behind.
- R2: A request for an interrupt whose pending bit is already set gives `req_accept` = 0. The stored vector of that interrupt stays unchanged.
- R3: An accepted request drives `req_accept` = 1 in the same cycle, which tells the source to set its activity flag. The interrupt's pending bit is set at the next clock edge.
- R4: After an accepted request, `irq_out` is 1 from the next cycle, with two exceptions where the line keeps its value. The first is when the request priority is below the highest pending priority. The second is when it is below the highest in-service priority.
- R5: "Highest" means the largest priority value. On equal priorities the lowest interrupt number wins. A set with no bits set has no highest entry.
- R6: An acknowledge drives `irq_out` to 0 in the next cycle, unless a later event in the same cycle raises it. In the next cycle `ack_vec` holds the vector of the highest pending interrupt, or the spurious vector when nothing is pending. The selected interrupt moves from the pending set to the in-service set.
- R7: An end-of-interrupt clears the highest in-service bit. If no in-service bit is set, it does nothing. It raises `irq_out` when a pending interrupt exists and either nothing remains in service or the highest pending priority exceeds the highest priority still in service.
- R8: After reset, the task priority is 15, so every request is rejected. The spurious vector is 0xFF, both sets are empty and `irq_out` is 0.
- R9: Events in one cycle are applied in this order: acknowledge, then end-of-interrupt, then delivery. A delivery therefore sees the sets as already changed by the other two. A request for the interrupt being acknowledged in the same cycle is accepted.
- R10: Writes to the task priority (`tp_wr`) and to the spurious vector (`spur_wr`) take effect from the next cycle. A request in the same cycle as a `tp_wr` is judged against the old threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Delivery request strobe |
| req_irq | input | IDX_W | Interrupt number of the request |
| req_prio | input | 4 | Priority of the request |
| req_vec | input | 8 | Vector of the request |
| req_accept | output | 1 | Request accepted; the source sets its activity flag |
| tp_wr | input | 1 | Task-priority write strobe |
| tp_wdata | input | 4 | New task priority |
| spur_wr | input | 1 | Spurious-vector write strobe |
| spur_wdata | input | 8 | New spurious vector |
| ack_rd | input | 1 | Acknowledge strobe |
| ack_vec | output | 8 | Vector returned by the last acknowledge |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
A delivery can fall in the same cycle as an acknowledge or as an end-of-interrupt. The bench provokes each pairing by asserting both strobes in one cycle.

In the acknowledge case, the delivery carries a priority either below or above the one being taken. A lower priority must leave the line low, because it is masked by the freshly in-service entry. A higher priority must raise the line.

In the end-of-interrupt case, the delivery carries a priority that only clears once the in-service entry is retired. The line must therefore rise.

Two further corner cases are covered. A same-cycle request for the very interrupt being acknowledged must be accepted. A threshold write in the same cycle as a request must not yet apply to that request.

// File: rtl/presenter_pkg.sv
// Shared types and reset constants for the interrupt presenter.
// Assumes priorities are 4 bits and vectors are 8 bits.
package presenter_pkg;
    typedef logic [3:0] prio_t;
    typedef logic [7:0] vec_t;

    localparam prio_t TP_RESET   = 4'hF;
    localparam vec_t  SPUR_RESET = 8'hFF;
endpackage

// File: rtl/prio_scan.sv
// Combinational search for the highest-priority member of a bit-set.
// It scans upward from index 0 with a strict greater-than, so the lowest
// index wins a tie. found_o is 0 for an empty set, and idx_o/prio_o are 0 then.
// Assumes N >= 2.
module prio_scan
    import presenter_pkg::*;
#(
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0] set_i,
    input  prio_t        prio_i [N],
    output logic         found_o,
    output logic [IW-1:0] idx_o,
    output prio_t        prio_o
);
    // Linear strict-greater scan over all members.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (set_i[i] && (!found_o || (prio_i[i] > prio_o))) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/src_table.sv
// Per-interrupt store of the priority and vector latched when a delivery
// is accepted. There is one write port and all entries are readable in parallel.
// Assumes wr_idx < N whenever wr_en is high.
module src_table
    import presenter_pkg::*;
#(
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  prio_t         wr_prio,
    input  vec_t          wr_vec,
    output prio_t         prio_o [N],
    output vec_t          vec_o  [N]
);
    for (genvar g = 0; g < N; g++) begin : g_entry
        // One entry: cleared at reset, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_o[g] <= '0;
                vec_o[g]  <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                prio_o[g] <= wr_prio;
                vec_o[g]  <= wr_vec;
            end
        end
    end
endmodule

// File: rtl/irq_presenter.sv
// One processor's interrupt presenter: a pending set, an in-service set,
// a task-priority threshold, a spurious vector and the interrupt line.
// Events in one cycle are applied in this order: acknowledge, then
// end-of-interrupt, then delivery. Each delivery is judged against the sets
// as already changed by the other two.
// Assumes single-cycle strobes from a decoder upstream.
module irq_presenter
    import presenter_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_irq,
    input  logic [3:0]       req_prio,
    input  logic [7:0]       req_vec,
    output logic             req_accept,
    input  logic             tp_wr,
    input  logic [3:0]       tp_wdata,
    input  logic             spur_wr,
    input  logic [7:0]       spur_wdata,
    input  logic             ack_rd,
    output logic [7:0]       ack_vec,
    input  logic             eoi_wr,
    output logic             irq_out
);
    localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

    logic [NUM_SRC-1:0] raised_q, serv_q;
    prio_t              tp_q;
    vec_t               spur_q, ack_vec_q;
    logic               irq_q;

    prio_t prio_tab [NUM_SRC];
    vec_t  vec_tab  [NUM_SRC];

    // Search results: r0 on stored pending, s1 after ack, s2 after eoi, r1 after ack.
    logic             r0_found, s1_found, s2_found, r1_found;
    logic [IDX_W-1:0] r0_idx, s1_idx, s2_idx, r1_idx;
    prio_t            r0_prio, s1_prio, s2_prio, r1_prio;

    logic [NUM_SRC-1:0] raised1, serv1, serv2, raised_d;
    logic               req_in_range, req_hit, accept, deliv_raise, eoi_raise, irq_d;
    logic               scan_unused;

    src_table #(.N(NUM_SRC)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_idx  (req_irq),
        .wr_prio (req_prio),
        .wr_vec  (req_vec),
        .prio_o  (prio_tab),
        .vec_o   (vec_tab)
    );

    prio_scan #(.N(NUM_SRC)) u_scan_r0 (
        .set_i(raised_q), .prio_i(prio_tab), .found_o(r0_found), .idx_o(r0_idx), .prio_o(r0_prio));

    // Acknowledge step: move the best pending entry into service.
    always_comb begin
        raised1 = raised_q;
        serv1   = serv_q;
        if (ack_rd && r0_found) begin
            raised1 = raised_q & ~(ONE << r0_idx);
            serv1   = serv_q   |  (ONE << r0_idx);
        end
    end

    prio_scan #(.N(NUM_SRC)) u_scan_s1 (
        .set_i(serv1), .prio_i(prio_tab), .found_o(s1_found), .idx_o(s1_idx), .prio_o(s1_prio));

    // End-of-interrupt step: retire the best in-service entry.
    always_comb begin
        serv2 = serv1;
        if (eoi_wr && s1_found) begin
            serv2 = serv1 & ~(ONE << s1_idx);
        end
    end

    prio_scan #(.N(NUM_SRC)) u_scan_s2 (
        .set_i(serv2), .prio_i(prio_tab), .found_o(s2_found), .idx_o(s2_idx), .prio_o(s2_prio));

    prio_scan #(.N(NUM_SRC)) u_scan_r1 (
        .set_i(raised1), .prio_i(prio_tab), .found_o(r1_found), .idx_o(r1_idx), .prio_o(r1_prio));

    assign scan_unused = ^{r0_prio, s1_prio, s2_idx, r1_idx};

    // Delivery step: threshold, duplicate and masking checks against post-ack/eoi sets.
    always_comb begin
        req_in_range = ({1'b0, req_irq} < (IDX_W + 1)'(NUM_SRC));
        req_hit      = req_in_range && raised1[req_irq];
        accept       = req_valid && req_in_range && (req_prio > tp_q) && !req_hit;
        deliv_raise  = accept
                     && !(r1_found && (req_prio < r1_prio))
                     && !(s2_found && (req_prio < s2_prio));
        eoi_raise    = eoi_wr && r1_found && (!s2_found || (r1_prio > s2_prio));
        raised_d     = accept ? (raised1 | (ONE << req_irq)) : raised1;
        irq_d        = ack_rd ? 1'b0 : irq_q;
        if (eoi_raise || deliv_raise) begin
            irq_d = 1'b1;
        end
    end

    // State update for sets, line, threshold, spurious vector and ack result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q  <= '0;
            serv_q    <= '0;
            irq_q     <= 1'b0;
            tp_q      <= TP_RESET;
            spur_q    <= SPUR_RESET;
            ack_vec_q <= '0;
        end else begin
            raised_q <= raised_d;
            serv_q   <= serv2;
            irq_q    <= irq_d;
            if (tp_wr) tp_q <= tp_wdata;
            if (spur_wr) spur_q <= spur_wdata;
            if (ack_rd) ack_vec_q <= r0_found ? vec_tab[r0_idx] : spur_q;
        end
    end

    assign req_accept = accept;
    assign ack_vec    = ack_vec_q;
    assign irq_out    = irq_q;

    AST_LOW_PRIO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_prio <= tp_q)) |-> !req_accept); // R1
    AST_DUP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack_rd && raised_q[req_irq]) |-> !req_accept); // R2
    AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> raised_q[$past(req_irq)]); // R3
    AST_RISE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> (raised_q != '0)); // R4
    AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !req_valid && !eoi_wr) |=> !irq_out); // R6
    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !ack_rd && (serv_q != '0)) |=>
        ($countones(serv_q) == $countones($past(serv_q)) - 1)); // R7
endmodule

// File: tb/test_irq_presenter.sv
module test_irq_presenter;
    localparam int N = 32;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_irq = '0;
    logic [3:0]    req_prio = '0;
    logic [7:0]    req_vec = '0;
    logic          req_accept;
    logic          tp_wr = 1'b0;
    logic [3:0]    tp_wdata = '0;
    logic          spur_wr = 1'b0;
    logic [7:0]    spur_wdata = '0;
    logic          ack_rd = 1'b0;
    logic [7:0]    ack_vec;
    logic          eoi_wr = 1'b0;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    irq_presenter #(.NUM_SRC(N)) i_irq_presenter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_irq(req_irq), .req_prio(req_prio), .req_vec(req_vec),
        .req_accept(req_accept),
        .tp_wr(tp_wr), .tp_wdata(tp_wdata),
        .spur_wr(spur_wr), .spur_wdata(spur_wdata),
        .ack_rd(ack_rd), .ack_vec(ack_vec), .eoi_wr(eoi_wr), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One cycle with any combination of strobes; checks req_accept when a request is driven.
    task automatic op(input bit a, input bit e, input bit rv, input int idx, input int pr,
                      input int vc, input bit exp_acc, input string tag);
        ack_rd = a; eoi_wr = e; req_valid = rv;
        req_irq = IW'(idx); req_prio = 4'(pr); req_vec = 8'(vc);
        #1;
        if (rv) check(req_accept == exp_acc, tag, int'(req_accept), int'(exp_acc));
        step();
        ack_rd = 1'b0; eoi_wr = 1'b0; req_valid = 1'b0;
    endtask

    task automatic deliver(input int idx, input int pr, input int vc, input bit exp_acc, input string tag);
        op(1'b0, 1'b0, 1'b1, idx, pr, vc, exp_acc, tag);
    endtask

    task automatic ack_expect(input int vc, input string tag);
        op(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, tag);
        check(ack_vec == 8'(vc), tag, int'(ack_vec), vc);
        check(irq_out == 1'b0, tag, int'(irq_out), 0);
    endtask

    task automatic eoi();
        op(1'b0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "eoi");
    endtask

    task automatic irq_expect(input bit exp, input string tag);
        check(irq_out == exp, tag, int'(irq_out), int'(exp));
    endtask

    task automatic set_tp(input int v);
        tp_wr = 1'b1; tp_wdata = 4'(v);
        step();
        tp_wr = 1'b0;
    endtask

    task automatic restart();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        set_tp(0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        irq_expect(1'b0, "R8 irq_out after reset");
        deliver(1, 15, 8'h11, 1'b0, "R8 tp=15 rejects prio 15");
        ack_expect(8'hFF, "R8 empty ack gives spurious 0xFF");
    endtask

    task automatic t_threshold();
        restart();
        set_tp(5);
        deliver(1, 5, 8'h15, 1'b0, "R1 prio equal to tp rejected");
        ack_expect(8'hFF, "R1 rejected request left nothing pending");
        deliver(2, 6, 8'h26, 1'b1, "R3 prio above tp accepted");
        irq_expect(1'b1, "R4 accepted request raises line");
        ack_expect(8'h26, "R6 ack returns vector");
    endtask

    task automatic t_writes();
        restart();
        spur_wr = 1'b1; spur_wdata = 8'hA5;
        step();
        spur_wr = 1'b0;
        ack_expect(8'hA5, "R10 new spurious vector");
        tp_wr = 1'b1; tp_wdata = 4'd9;
        deliver(3, 6, 8'h36, 1'b1, "R10 same-cycle tp write uses old tp");
        tp_wr = 1'b0;
        deliver(4, 7, 8'h47, 1'b0, "R10 new tp applies next cycle");
    endtask

    task automatic t_missed();
        restart();
        deliver(4, 6, 8'h44, 1'b1, "R3 first delivery");
        deliver(4, 9, 8'h99, 1'b0, "R2 duplicate dropped");
        irq_expect(1'b1, "R2 line unchanged");
        ack_expect(8'h44, "R2 stored vector unchanged");
        ack_expect(8'hFF, "R2 duplicate left no extra entry");
    endtask

    task automatic t_tie();
        restart();
        deliver(7, 8, 8'h77, 1'b1, "R5 tie a");
        deliver(2, 8, 8'h22, 1'b1, "R5 tie b");
        ack_expect(8'h22, "R5 lowest index wins tie");
        ack_expect(8'h77, "R5 second of tie");
        ack_expect(8'hFF, "R6 spurious after drain");
    endtask

    task automatic t_hidden_raised();
        restart();
        deliver(20, 9, 8'h20, 1'b1, "R3 d20");
        deliver(21, 9, 8'h21, 1'b1, "R3 d21");
        ack_expect(8'h20, "R6 ack 20");
        deliver(22, 3, 8'h22, 1'b1, "R3 d22 low");
        irq_expect(1'b0, "R4 hidden by higher pending");
        deliver(23, 12, 8'h23, 1'b1, "R3 d23 high");
        irq_expect(1'b1, "R4 high request raises");
        ack_expect(8'h23, "R5 highest priority acked first");
    endtask

    task automatic t_eoi();
        restart();
        deliver(1, 7, 8'h01, 1'b1, "R3 d1");
        ack_expect(8'h01, "R6 ack 1");
        deliver(2, 9, 8'h02, 1'b1, "R3 d2");
        irq_expect(1'b1, "R4 above in-service raises");
        ack_expect(8'h02, "R6 ack 2");
        deliver(3, 8, 8'h03, 1'b1, "R3 d3");
        irq_expect(1'b0, "R4 hidden by in-service");
        eoi();
        irq_expect(1'b1, "R7 eoi retires top, pending exceeds rest");
        ack_expect(8'h03, "R6 ack 3");
        eoi(); eoi();
        eoi();
        irq_expect(1'b0, "R7 eoi on empty in-service has no effect");
        ack_expect(8'hFF, "R7 all retired");
    endtask

    task automatic t_eoi_no_raise();
        restart();
        deliver(1, 7, 8'h01, 1'b1, "R3 d1");
        ack_expect(8'h01, "R6 ack 1");
        deliver(2, 9, 8'h02, 1'b1, "R3 d2");
        ack_expect(8'h02, "R6 ack 2");
        deliver(3, 5, 8'h03, 1'b1, "R3 d3");
        eoi();
        irq_expect(1'b0, "R7 pending below remaining in-service");
        eoi();
        irq_expect(1'b1, "R7 nothing left in service raises");
    endtask

    task automatic t_same_cycle();
        restart();
        deliver(5, 6, 8'h05, 1'b1, "R3 d5");
        op(1'b1, 1'b0, 1'b1, 6, 4, 8'h06, 1'b1, "R9 ack+low delivery accepted");
        check(ack_vec == 8'h05, "R9 ack+delivery vector", int'(ack_vec), 8'h05);
        irq_expect(1'b0, "R9 low delivery hidden by new in-service");
        eoi();
        irq_expect(1'b1, "R9 eoi then raises for pending");
        ack_expect(8'h06, "R9 ack 6");

        restart();
        deliver(5, 6, 8'h05, 1'b1, "R3 d5");
        op(1'b1, 1'b0, 1'b1, 6, 8, 8'h06, 1'b1, "R9 ack+high delivery accepted");
        irq_expect(1'b1, "R9 high delivery raises after ack");

        restart();
        deliver(5, 6, 8'h05, 1'b1, "R3 d5");
        op(1'b1, 1'b0, 1'b1, 5, 9, 8'h55, 1'b1, "R9 same index as ack accepted");
        check(ack_vec == 8'h05, "R9 old vector returned", int'(ack_vec), 8'h05);
        ack_expect(8'h55, "R9 new vector stored");

        restart();
        deliver(5, 6, 8'h05, 1'b1, "R3 d5");
        ack_expect(8'h05, "R6 ack 5");
        op(1'b0, 1'b1, 1'b1, 6, 5, 8'h06, 1'b1, "R9 eoi+delivery accepted");
        irq_expect(1'b1, "R9 eoi before delivery unmasks");
        ack_expect(8'h06, "R9 ack 6 after eoi");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_threshold();
        t_writes();
        t_missed();
        t_tie();
        t_hidden_raised();
        t_eoi();
        t_eoi_no_raise();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule